// File: doc/BRIEF.md
# Periodic Countdown Timer

A down-counting timer peripheral behind a small word-addressed register bus. Software loads a period value and then starts or stops the count with one-shot command bits in the control word. The counter moves down by one on every clock while it runs. When it reaches its end it raises a timeout flag. It then either halts with a count of zero, or reloads the period and keeps going when continuous mode is selected.

A level interrupt is the timeout flag masked by an interrupt-enable bit. Any write to the status word clears the flag, whatever the data. The live count can be read at any time through a read-only snapshot word. Reads return data combinationally for the presented address whenever the request is valid. Addresses that map to no register read as zero, and writes to them have no effect.

Top module: `cdt_timer`

## Requirements
- R1: After reset every register reads zero, the counter is halted and `irq_o` is low.
- R2: The byte address selects a word by index = address >> 2: status at byte 0, control at 4, period at 8, snapshot at 12. Any other index reads zero and ignores writes. `rsp_rdata_o` is zero while `req_valid_i` is low.
- R3: Status bit 0 is the timeout flag and bit 1 is the running state. Control reads back bit 0 = interrupt enable and bit 1 = continuous mode. Control bits 2 (start) and 3 (stop) always read as zero. All other bits read zero.
- R4: A period write stores the value and loads it into the counter on the same clock edge. That load replaces the count step of that cycle, and the counter keeps its run state.
- R5: While running, the counter decreases by one per clock. While halted, it holds its value. The snapshot word returns the live count.
- R6: A running counter expires on the clock in which its value is 1 or 0. Expiry sets the timeout flag. In one-shot mode the count becomes 0 and the counter halts.
- R7: In continuous mode (control bit 1 = 1) expiry reloads the count from the period register and the counter keeps running.
- R8: Writing control bit 2 starts the counter and writing bit 3 stops it. When both are set, stop wins. Neither bit acts on later cycles, and a start with a count of zero expires on the following clock.
- R9: Any write to the status word clears the timeout flag. An expiry in the same cycle wins, and the flag stays set.
- R10: `irq_o` equals the timeout flag ANDed with control bit 0.
- R11: Writes to the snapshot word change neither the count nor any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_rdata_o | output | DATA_W | Read data for the presented address |
| irq_o | output | 1 | Level interrupt |

## Verification
The counter is driven in one-shot mode from a mid-sized period and in continuous mode from a short period. These two runs separate halting from reloading at expiry. A period of zero makes every clock an expiry, which exposes the priority between a status-clear write and an expiry in the same cycle, and the immediate expiry after a start from zero. A combined start-and-stop write and a period write during a run test command priority and the load-over-decrement rule. Writes to the snapshot and to unmapped words, followed by readback of every register, show that these writes leave all state unchanged.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned REG_COUNT = 4;

  typedef enum logic [1:0] {
    REG_STATUS  = 2'd0,
    REG_CONTROL = 2'd1,
    REG_PERIOD  = 2'd2,
    REG_SNAP    = 2'd3
  } cdt_reg_e;

  // status bit positions
  localparam int unsigned ST_TIMEOUT = 0;
  localparam int unsigned ST_RUN     = 1;
  // control bit positions
  localparam int unsigned CT_IE    = 0;
  localparam int unsigned CT_CONT  = 1;
  localparam int unsigned CT_START = 2;
  localparam int unsigned CT_STOP  = 3;
endpackage

// File: rtl/cdt_bus_decode.sv
module cdt_bus_decode
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [REG_COUNT-1:0] wr_sel_o,
  output logic [1:0]        rd_idx_o,
  output logic              rd_hit_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             in_range;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign in_range = ({{(32-IDX_W){1'b0}}, word_idx} < 32'(REG_COUNT));
  assign rd_hit_o = valid_i & in_range;
  assign rd_idx_o = word_idx[1:0];

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_wsel
    assign wr_sel_o[r] = valid_i & write_i & in_range & (word_idx == IDX_W'(r));
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              start_cmd_i,
  input  logic              stop_cmd_i,
  input  logic              cont_mode_i,
  input  logic [DATA_W-1:0] reload_val_i,
  output logic [DATA_W-1:0] count_o,
  output logic              running_o,
  output logic              tick_o,
  output logic              expire_o
);
  logic [DATA_W-1:0] count_q;
  logic              running_q;

  // true when the current value is the last one before expiry
  function automatic logic cnt_is_last(input logic [DATA_W-1:0] c);
    return (c[DATA_W-1:1] == '0);
  endfunction

  function automatic logic [DATA_W-1:0] cnt_step(input logic [DATA_W-1:0] c);
    return c - DATA_W'(1);
  endfunction

  assign tick_o   = running_q & ~load_en_i;
  assign expire_o = tick_o & cnt_is_last(count_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (load_en_i) begin
      count_q <= load_val_i;
    end else if (expire_o) begin
      count_q <= cont_mode_i ? reload_val_i : '0;
    end else if (tick_o) begin
      count_q <= cnt_step(count_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
    end else if (stop_cmd_i) begin
      running_q <= 1'b0;
    end else if (start_cmd_i) begin
      running_q <= 1'b1;
    end else if (expire_o && !cont_mode_i) begin
      running_q <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign running_o = running_q;
endmodule

// File: rtl/cdt_ctrl_regs.sv
module cdt_ctrl_regs
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_status_i,
  input  logic              wr_control_i,
  input  logic              wr_period_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic              timeout_o,
  output logic              irq_en_o,
  output logic              cont_o,
  output logic [DATA_W-1:0] period_o
);
  logic              timeout_q, irq_en_q, cont_q;
  logic [DATA_W-1:0] period_q;

  // expiry dominates a clearing write so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           timeout_q <= 1'b0;
    else if (expire_i)     timeout_q <= 1'b1;
    else if (wr_status_i)  timeout_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      cont_q   <= 1'b0;
    end else if (wr_control_i) begin
      irq_en_q <= wdata_i[CT_IE];
      cont_q   <= wdata_i[CT_CONT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          period_q <= '0;
    else if (wr_period_i) period_q <= wdata_i;
  end

  assign timeout_o = timeout_q;
  assign irq_en_o  = irq_en_q;
  assign cont_o    = cont_q;
  assign period_o  = period_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  logic [REG_COUNT-1:0] wr_sel;
  logic [1:0]           rd_idx;
  logic                 rd_hit;

  // named internal events, observed by the bound checker
  logic                 wr_status_w, wr_control_w, wr_period_w, wr_snap_w;
  logic                 start_cmd_w, stop_cmd_w;
  logic                 tick_w, expire_w;
  logic                 running_w, timeout_w, irq_en_w, cont_w;
  logic [DATA_W-1:0]    count_w, period_w;

  cdt_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .addr_i   (req_addr_i),
    .wr_sel_o (wr_sel),
    .rd_idx_o (rd_idx),
    .rd_hit_o (rd_hit)
  );

  assign wr_status_w  = wr_sel[REG_STATUS];
  assign wr_control_w = wr_sel[REG_CONTROL];
  assign wr_period_w  = wr_sel[REG_PERIOD];
  assign wr_snap_w    = wr_sel[REG_SNAP];
  assign start_cmd_w  = wr_control_w & req_wdata_i[CT_START];
  assign stop_cmd_w   = wr_control_w & req_wdata_i[CT_STOP];

  cdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_en_i    (wr_period_w),
    .load_val_i   (req_wdata_i),
    .start_cmd_i  (start_cmd_w),
    .stop_cmd_i   (stop_cmd_w),
    .cont_mode_i  (cont_w),
    .reload_val_i (period_w),
    .count_o      (count_w),
    .running_o    (running_w),
    .tick_o       (tick_w),
    .expire_o     (expire_w)
  );

  cdt_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_status_i  (wr_status_w),
    .wr_control_i (wr_control_w),
    .wr_period_i  (wr_period_w),
    .wdata_i      (req_wdata_i),
    .expire_i     (expire_w),
    .timeout_o    (timeout_w),
    .irq_en_o     (irq_en_w),
    .cont_o       (cont_w),
    .period_o     (period_w)
  );

  always_comb begin
    rsp_rdata_o = '0;
    if (rd_hit) begin
      unique case (cdt_reg_e'(rd_idx))
        REG_STATUS: begin
          rsp_rdata_o[ST_TIMEOUT] = timeout_w;
          rsp_rdata_o[ST_RUN]     = running_w;
        end
        REG_CONTROL: begin
          rsp_rdata_o[CT_IE]   = irq_en_w;
          rsp_rdata_o[CT_CONT] = cont_w;
        end
        REG_PERIOD: rsp_rdata_o = period_w;
        REG_SNAP:   rsp_rdata_o = count_w;
        default:    rsp_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = timeout_w & irq_en_w;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_period,
  input logic              wr_control,
  input logic              wr_snap,
  input logic [DATA_W-1:0] wdata,
  input logic              tick,
  input logic              expire,
  input logic              cont,
  input logic              running,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] period,
  input logic              timeout,
  input logic              irq_en,
  input logic              irq
);
  p_period_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_period |=> (count == $past(wdata)) && (period == $past(wdata)));

  p_count_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !expire) |=> (count == $past(count) - DATA_W'(1)));

  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !wr_period) |=> $stable(count));

  p_timeout_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> timeout);

  p_oneshot_halt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !cont && !(wr_control && wdata[2])) |=> (!running && count == '0));

  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && cont && !(wr_control && wdata[3])) |=> (running && count == $past(period)));

  p_stop_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_control && wdata[3]) |=> !running);

  p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |-> !irq);

  p_irq_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq) |-> timeout);

  p_snap_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_snap && !running) |=> $stable(count) && $stable(period));
endmodule

bind cdt_timer cdt_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_period  (wr_period_w),
  .wr_control (wr_control_w),
  .wr_snap    (wr_snap_w),
  .wdata      (req_wdata_i),
  .tick       (tick_w),
  .expire     (expire_w),
  .cont       (cont_w),
  .running    (running_w),
  .count      (count_w),
  .period     (period_w),
  .timeout    (timeout_w),
  .irq_en     (irq_en_w),
  .irq        (irq_o)
);

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic          write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk; // 125 MHz

  cdt_timer #(.ADDR_W(AW), .DATA_W(DW)) u_cdt_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference state
  logic [31:0] m_cnt = 0, m_per = 0;
  bit m_run = 0, m_to = 0, m_ie = 0, m_cont = 0;

  function automatic logic [31:0] m_read(input bit v, input int a);
    int idx;
    if (!v) return 32'h0;
    idx = a / 4;
    case (idx)
      0: return {30'h0, m_run, m_to};
      1: return {30'h0, m_cont, m_ie};
      2: return m_per;
      3: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_run = 0; m_to = 0; m_ie = 0; m_cont = 0;
    end else begin
      int idx;
      bit we, fired;
      logic [31:0] n_cnt;
      bit n_run, n_to;
      idx = int'(addr) / 4;
      we = valid && write;
      n_cnt = m_cnt; n_run = m_run; n_to = m_to; fired = 0;
      if (we && idx == 2) begin
        m_per = wdata; n_cnt = wdata;
      end else if (m_run) begin
        if (m_cnt == 0 || m_cnt == 1) begin
          fired = 1; n_to = 1;
          if (m_cont) n_cnt = m_per;
          else begin n_cnt = 0; n_run = 0; end
        end else n_cnt = m_cnt - 1;
      end
      if (we && idx == 1) begin
        if (wdata[3]) n_run = 0;
        else if (wdata[2]) n_run = 1;
        m_ie = wdata[0]; m_cont = wdata[1];
      end
      if (we && idx == 0 && !fired) n_to = 0;
      m_cnt = n_cnt; m_run = n_run; m_to = n_to;
    end
    #2;
    check(cur_req, rdata, m_read(valid, int'(addr)));
    check("R10", {31'h0, irq}, {31'h0, m_to & m_ie});
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    valid = 1; write = 1; addr = AW'(a); wdata = d;
    @(negedge clk);
    write = 0; addr = AW'(12); wdata = '0;
  endtask

  task automatic read_chk(input string req, input int a, input logic [31:0] exp);
    @(negedge clk);
    valid = 1; write = 0; addr = AW'(a);
    #1 check(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    read_chk("R1", 0, 32'h0);
    read_chk("R1", 4, 32'h0);
    read_chk("R1", 8, 32'h0);
    read_chk("R1", 12, 32'h0);
    check("R1", {31'h0, irq}, 32'h0);

    // period load while halted, snapshot shows it
    cur_req = "R4";
    bus_write(8, 32'd10);
    read_chk("R4", 8, 32'd10);
    read_chk("R4", 12, 32'd10);

    // one-shot run with interrupt enabled
    cur_req = "R6";
    bus_write(4, 32'h5);
    read_chk("R5", 12, 32'd9);
    read_chk("R3", 4, 32'h1);
    idle(15);
    read_chk("R6", 0, 32'h1);
    read_chk("R6", 12, 32'h0);
    check("R10", {31'h0, irq}, 32'h1);

    // status clear with arbitrary data
    cur_req = "R9";
    bus_write(0, 32'h0);
    read_chk("R9", 0, 32'h0);
    check("R10", {31'h0, irq}, 32'h0);

    // continuous mode
    cur_req = "R7";
    bus_write(8, 32'd3);
    bus_write(4, 32'h7);
    idle(20);
    read_chk("R7", 0, 32'h3);
    read_chk("R3", 4, 32'h3);
    cur_req = "R4";
    bus_write(8, 32'd50);
    read_chk("R4", 12, 32'd49);
    cur_req = "R8";
    bus_write(4, 32'hB);
    read_chk("R8", 0, 32'h1);
    idle(3);
    read_chk("R8", 12, 32'd47);

    // start and stop together: stop wins
    bus_write(4, 32'hC);
    read_chk("R8", 0, 32'h1);
    read_chk("R3", 4, 32'h0);
    check("R10", {31'h0, irq}, 32'h0);

    // start from a zero count expires on the next clock
    bus_write(0, 32'hFFFF_FFFF);
    bus_write(8, 32'd0);
    bus_write(4, 32'h4);
    read_chk("R8", 0, 32'h1);

    // clear in the same cycle as a continuous expiry: expiry wins
    cur_req = "R9";
    bus_write(4, 32'h6);
    bus_write(0, 32'h0);
    read_chk("R9", 0, 32'h3);
    bus_write(4, 32'h8);
    read_chk("R9", 0, 32'h1);

    // snapshot writes ignored
    cur_req = "R11";
    bus_write(8, 32'd77);
    bus_write(12, 32'd5);
    read_chk("R11", 12, 32'd77);
    read_chk("R11", 8, 32'd77);
    read_chk("R11", 0, 32'h1);

    // unmapped words and invalid requests
    cur_req = "R2";
    bus_write(16, 32'hFFFF);
    bus_write(60, 32'h1234);
    read_chk("R2", 16, 32'h0);
    read_chk("R2", 60, 32'h0);
    read_chk("R2", 8, 32'd77);
    read_chk("R2", 4, 32'h0);
    @(negedge clk);
    valid = 0; addr = AW'(8);
    #1 check("R2", rdata, 32'h0);
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule